// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular ring of transmit descriptors held in a 16-bit buffer memory. Each descriptor takes eight bytes and gives a buffer address, a byte count, an ownership flag and two frame flags, one marking the start of a frame and one marking its end. When software posts a transmit demand and the transmitter is enabled, the engine walks the ring from its current index. For every descriptor it owns, it streams that descriptor's buffer out as bytes on a valid/ready stream, marking the first and last byte of each frame. It then hands the descriptor back by writing it to memory with the ownership flag cleared.

A frame may span several descriptors. The engine keeps a frame open from its start descriptor until its end descriptor. It raises single-cycle events when a frame completes, when an open frame is abandoned by a fresh start, and when a scan runs round the whole ring. The memory port is a plain synchronous one: read data is valid the cycle after a read strobe, and writes take effect at the strobe.

Top module: `txring_engine`

## Requirements
- R1: Descriptor i occupies four 16-bit words at byte addresses ring_base + 8*i + 0/2/4/6 (ring_base 8-byte aligned). The ring holds 2^ring_log descriptors. After reset the index is 0.
- R2: The buffer start address is word0 with word1[7:0] as bits 23:16, and the byte count is 4096 minus word2[11:0]. Bytes leave in increasing address order, and within a memory word the even address is the low byte.
- R3: A scan halts at a descriptor whose OWN bit (word1 bit 15) is 0 or whose word2[15:12] is not 4'hF. That descriptor is neither streamed nor written, and the index stays on it.
- R4: A descriptor whose byte count is below 12 or above 1900 halts the scan the same way, without being consumed.
- R5: A descriptor without STP (word1 bit 9) while no frame is open halts the scan unconsumed. A descriptor with STP while a frame is open pulses evt_drop and starts a new frame.
- R6: out_first marks the first byte of an STP descriptor. out_last marks the last byte of a descriptor with ENP (word1 bit 8). evt_tint pulses for one cycle right after that last byte is accepted.
- R7: A consumed descriptor has word1 written back with bit 15 cleared, and words 2 and 3 written back unchanged. The index then advances, wrapping from 2^ring_log-1 to 0.
- R8: A demand pulse sets demand_pend. A scan starts only while tx_enable is high, and starting a scan clears demand_pend.
- R9: When advancing would return the index to the scan's starting index, the scan ends and evt_exhaust pulses.
- R10: While out_valid is high and out_ready is low, out_data, out_first and out_last hold.
- R11: Reset leaves out_valid, the event outputs, demand_pend and both memory strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmitter enabled |
| demand | input | 1 | Transmit demand pulse |
| ring_base | input | 24 | Byte address of descriptor 0 |
| ring_log | input | 3 | Log2 of the ring length |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory byte address (even) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after mem_rd |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| out_ready | input | 1 | Downstream ready |
| evt_tint | output | 1 | Frame completed pulse |
| evt_drop | output | 1 | Open frame abandoned pulse |
| evt_exhaust | output | 1 | Ring wrapped to scan start pulse |
| demand_pend | output | 1 | Demand posted but not yet served |
| ring_idx | output | 7 | Current descriptor index |

## Verification
The engine is driven with a single even-aligned frame, with a two-descriptor chain that starts on an odd address under a toggling ready, and with a full two-entry ring. Together these separate correct byte-lane order and word reuse from refetch errors, and show whether chained frames carry exactly one first and one last marker. Rejected descriptors are tried one defect at a time: OWN clear, bad marker nibble, short count, and a missing start flag. Each case shows that nothing is streamed or written back and the index stays put. An abandoned open frame, a demand posted while disabled, and a long stall cover the drop event, the demand gate and output hold.

// File: rtl/tdre_pkg.sv
package tdre_pkg;
    localparam int ADDR_W    = 24;
    localparam int LEN_W     = 13;
    localparam int LEN_MIN   = 12;
    localparam int LEN_MAX   = 1900;
    localparam int OWN_BIT   = 15;
    localparam int STP_BIT   = 9;
    localparam int ENP_BIT   = 8;

    typedef logic [3:0][15:0] desc_words_t;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic [LEN_W-1:0]  byte_len;
        logic              own;
        logic              stp;
        logic              enp;
        logic              usable;
    } desc_info_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DREQ, ST_DCAP, ST_CHECK, ST_BREQ,
        ST_BCAP, ST_SEND, ST_WB1, ST_WB2, ST_WB3
    } eng_state_t;

    function automatic logic [LEN_W-1:0] count_from_field(input logic [11:0] f);
        return LEN_W'(4096) - {1'b0, f};
    endfunction
endpackage

// File: rtl/tdre_decode.sv
module tdre_decode
    import tdre_pkg::*;
(
    input  desc_words_t words,
    output desc_info_t  info
);
    always_comb begin
        info.buf_addr = {words[1][7:0], words[0]};
        info.byte_len = count_from_field(words[2][11:0]);
        info.own      = words[1][OWN_BIT];
        info.stp      = words[1][STP_BIT];
        info.enp      = words[1][ENP_BIT];
        info.usable   = info.own && (words[2][15:12] == 4'hF)
                     && (info.byte_len >= LEN_W'(LEN_MIN))
                     && (info.byte_len <= LEN_W'(LEN_MAX));
    end
endmodule

// File: rtl/tdre_ring_idx.sv
module tdre_ring_idx #(
    parameter int LOG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOG_W-1:0] ring_log,
    input  logic             scan_start,
    input  logic             advance,
    output logic [(1<<LOG_W)-2:0] idx,
    output logic             wrap_hit
);
    localparam int IDX_W = (1 << LOG_W) - 1;

    logic [IDX_W-1:0] mask, start_idx, nxt;

    assign mask     = (IDX_W'(1) << ring_log) - IDX_W'(1);
    assign nxt      = (idx + IDX_W'(1)) & mask;
    assign wrap_hit = (nxt == start_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            start_idx <= '0;
        end else begin
            if (scan_start) start_idx <= idx;
            if (advance)    idx       <= nxt;
        end
    end

    // R1
    idx_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        advance |=> ((idx & ~mask) == '0));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import tdre_pkg::*;
#(
    parameter int LOG_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_enable,
    input  logic        demand,
    input  logic [23:0] ring_base,
    input  logic [2:0]  ring_log,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [23:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_first,
    output logic        out_last,
    input  logic        out_ready,
    output logic        evt_tint,
    output logic        evt_drop,
    output logic        evt_exhaust,
    output logic        demand_pend,
    output logic [6:0]  ring_idx
);
    localparam int IDX_W = (1 << LOG_W) - 1;

    eng_state_t        state;
    desc_words_t       dw;
    desc_info_t        info;
    logic [1:0]        wk;
    logic [ADDR_W-1:0] baddr, desc_base;
    logic [LEN_W-1:0]  remain;
    logic [15:0]       bword;
    logic              frame_open, first_pend;
    logic              scan_start, advance, wrap_hit, take;
    logic [IDX_W-1:0]  idx;

    tdre_decode u_dec (.words(dw), .info(info));

    tdre_ring_idx #(.LOG_W(LOG_W)) u_idx (
        .clk(clk), .rst(rst), .ring_log(ring_log[LOG_W-1:0]),
        .scan_start(scan_start), .advance(advance),
        .idx(idx), .wrap_hit(wrap_hit));

    assign ring_idx   = 7'(idx);
    assign scan_start = (state == ST_IDLE) && demand_pend && tx_enable;
    assign advance    = (state == ST_WB3);
    assign desc_base  = ring_base + ADDR_W'({idx, 3'b000});
    assign take       = (state == ST_SEND) && out_ready;

    assign out_valid = (state == ST_SEND);
    assign out_data  = baddr[0] ? bword[15:8] : bword[7:0];
    assign out_first = out_valid && first_pend;
    assign out_last  = out_valid && info.enp && (remain == LEN_W'(1));

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_DREQ: begin
                mem_rd   = 1'b1;
                mem_addr = desc_base + ADDR_W'({wk, 1'b0});
            end
            ST_BREQ: begin
                mem_rd   = 1'b1;
                mem_addr = {baddr[ADDR_W-1:1], 1'b0};
            end
            ST_WB1: begin
                mem_wr    = 1'b1;
                mem_addr  = desc_base + ADDR_W'(2);
                mem_wdata = dw[1] & ~(16'h1 << OWN_BIT);
            end
            ST_WB2: begin
                mem_wr    = 1'b1;
                mem_addr  = desc_base + ADDR_W'(4);
                mem_wdata = dw[2];
            end
            ST_WB3: begin
                mem_wr    = 1'b1;
                mem_addr  = desc_base + ADDR_W'(6);
                mem_wdata = dw[3];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            dw          <= '0;
            wk          <= '0;
            baddr       <= '0;
            remain      <= '0;
            bword       <= '0;
            frame_open  <= 1'b0;
            first_pend  <= 1'b0;
            demand_pend <= 1'b0;
            evt_tint    <= 1'b0;
            evt_drop    <= 1'b0;
            evt_exhaust <= 1'b0;
        end else begin
            evt_tint    <= 1'b0;
            evt_drop    <= 1'b0;
            evt_exhaust <= 1'b0;
            if (scan_start)  demand_pend <= demand;
            else if (demand) demand_pend <= 1'b1;
            unique case (state)
                ST_IDLE: if (scan_start) begin
                    wk    <= '0;
                    state <= ST_DREQ;
                end
                ST_DREQ: state <= ST_DCAP;
                ST_DCAP: begin
                    dw[wk] <= mem_rdata;
                    wk     <= wk + 2'd1;
                    state  <= (wk == 2'd3) ? ST_CHECK : ST_DREQ;
                end
                ST_CHECK: begin
                    if (!info.usable || (!info.stp && !frame_open)) begin
                        state <= ST_IDLE;
                    end else begin
                        evt_drop   <= info.stp && frame_open;
                        frame_open <= 1'b1;
                        first_pend <= info.stp;
                        baddr      <= info.buf_addr;
                        remain     <= info.byte_len;
                        state      <= ST_BREQ;
                    end
                end
                ST_BREQ: state <= ST_BCAP;
                ST_BCAP: begin
                    bword <= mem_rdata;
                    state <= ST_SEND;
                end
                ST_SEND: if (out_ready) begin
                    first_pend <= 1'b0;
                    remain     <= remain - LEN_W'(1);
                    baddr      <= baddr + ADDR_W'(1);
                    if (remain == LEN_W'(1)) begin
                        if (info.enp) begin
                            frame_open <= 1'b0;
                            evt_tint   <= 1'b1;
                        end
                        state <= ST_WB1;
                    end else if (baddr[0]) begin
                        state <= ST_BREQ;
                    end
                end
                ST_WB1: state <= ST_WB2;
                ST_WB2: state <= ST_WB3;
                ST_WB3: begin
                    wk <= '0;
                    if (wrap_hit) begin
                        evt_exhaust <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        state <= ST_DREQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_first) && $stable(out_last)));

    // R6
    tint_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        evt_tint |-> $past(out_valid && out_ready && out_last));

    // R7
    wb_not_word0_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ((mem_addr - ring_base) & 24'h7) != 24'h0);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8
    demand_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_start && !demand) |=> !demand_pend);
endmodule

// File: tb/txring_engine_test.sv
module txring_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_enable = 1'b0, demand = 1'b0;
    logic [23:0] ring_base = 24'h40;
    logic [2:0]  ring_log = 3'd2;
    logic        mem_rd, mem_wr;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        out_valid, out_first, out_last, out_ready;
    logic [7:0]  out_data;
    logic        evt_tint, evt_drop, evt_exhaust, demand_pend;
    logic [6:0]  ring_idx;

    int checks = 0, errors = 0, cyc = 0;
    int rdy_mode = 0, tgl = 0;
    logic [15:0] mem [0:2047];
    logic [7:0]  cap_d [0:63];
    logic        cap_f [0:63];
    logic        cap_l [0:63];
    int cap_n = 0, n_tint = 0, n_drop = 0, n_exh = 0, n_wr = 0, n_rd = 0;

    txring_engine uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:1]];
        if (mem_wr) n_wr <= n_wr + 1;
        if (mem_rd) n_rd <= n_rd + 1;
        if (out_valid && out_ready && cap_n < 64) begin
            cap_d[cap_n] <= out_data;
            cap_f[cap_n] <= out_first;
            cap_l[cap_n] <= out_last;
            cap_n <= cap_n + 1;
        end
        if (evt_tint)    n_tint <= n_tint + 1;
        if (evt_drop)    n_drop <= n_drop + 1;
        if (evt_exhaust) n_exh  <= n_exh + 1;
    end

    always @(negedge clk) begin
        tgl <= tgl + 1;
        out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? tgl[0] : 1'b0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d exp %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 5 + 1) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_enable = 1'b0; demand = 1'b0; rdy_mode = 0;
        ring_base = 24'h40; ring_log = 3'd2;
        for (int w = 0; w < 2048; w++) mem[w] = {pat(2*w+1), pat(2*w)};
        for (int w = 32; w < 160; w++) mem[w] = 16'h0;
        cycles(3);
        rst = 1'b0;
        cap_n = 0; n_tint = 0; n_drop = 0; n_exh = 0; n_wr = 0; n_rd = 0;
        @(negedge clk);
    endtask

    task automatic put_desc(input int i, input int addr, input int len,
                            input bit own, input bit stp, input bit enp, input logic [3:0] nib);
        int w;
        w = (32'(ring_base) + 8*i) / 2;
        mem[w]   = 16'(addr & 16'hFFFF);
        mem[w+1] = {own, 5'b0, stp, enp, 8'((addr >> 16) & 255)};
        mem[w+2] = {nib, 12'((4096 - len) & 12'hFFF)};
        mem[w+3] = 16'h1230 + 16'(i);
    endtask

    task automatic kick();
        tx_enable = 1'b1;
        demand = 1'b1; @(negedge clk); demand = 1'b0;
        cycles(400);
    endtask

    task automatic check_bytes(input int start, input int addr, input int len, input string req);
        int bad = 0, ba = 0, ea = 0;
        for (int k = 0; k < len; k++)
            if (cap_d[start+k] !== pat(addr+k) && bad == 0) begin
                bad = 1; ba = cap_d[start+k]; ea = pat(addr+k);
            end
        chk(bad == 0, req, ba, ea);
    endtask

    task automatic t_reset();
        do_reset();
        chk(out_valid == 0 && evt_tint == 0 && evt_drop == 0 && evt_exhaust == 0,
            "R11 outputs idle", out_valid, 0);
        chk(demand_pend == 0 && mem_rd == 0 && mem_wr == 0, "R11 strobes low", demand_pend, 0);
        chk(ring_idx == 0, "R1 index 0", ring_idx, 0);
    endtask

    task automatic t_single();
        do_reset();
        put_desc(0, 'h300, 12, 1, 1, 1, 4'hF);
        kick();
        chk(cap_n == 12, "R2 byte count", cap_n, 12);
        check_bytes(0, 'h300, 12, "R2 bytes even start");
        chk(cap_f[0] == 1 && cap_l[11] == 1 && cap_l[10] == 0, "R6 markers", cap_l[11], 1);
        chk(n_tint == 1, "R6 tint", n_tint, 1);
        chk(mem[(32'h40/2)+1] == 16'h0300, "R7 own cleared", mem[33], 16'h0300);
        chk(mem[(32'h40/2)+3] == 16'h1230, "R7 word3 kept", mem[35], 16'h1230);
        chk(ring_idx == 1 && n_wr == 3, "R3 stop at unowned, R7 advance", ring_idx, 1);
    endtask

    task automatic t_chain();
        do_reset();
        rdy_mode = 1;
        put_desc(0, 'h301, 13, 1, 1, 0, 4'hF);
        put_desc(1, 'h400, 12, 1, 0, 1, 4'hF);
        kick();
        chk(cap_n == 25, "R2 chain count", cap_n, 25);
        check_bytes(0, 'h301, 13, "R2 odd start bytes");
        check_bytes(13, 'h400, 12, "R2 second buffer bytes");
        chk(cap_f[0] == 1 && cap_f[13] == 0 && cap_l[12] == 0 && cap_l[24] == 1,
            "R6 chain markers", cap_l[24], 1);
        chk(n_tint == 1 && ring_idx == 2, "R7 chain tint/index", ring_idx, 2);
    endtask

    task automatic t_reject(input int len, input bit own, input bit stp, input logic [3:0] nib,
                            input string req);
        do_reset();
        put_desc(0, 'h300, len, own, stp, 1, nib);
        kick();
        chk(cap_n == 0 && n_wr == 0, req, cap_n + n_wr, 0);
        chk(ring_idx == 0 && mem[33][15] == own, req, ring_idx, 0);
    endtask

    task automatic t_drop();
        do_reset();
        put_desc(0, 'h300, 12, 1, 1, 0, 4'hF);
        put_desc(1, 'h400, 14, 1, 1, 1, 4'hF);
        kick();
        chk(n_drop == 1, "R5 drop pulse", n_drop, 1);
        chk(cap_n == 26 && cap_f[12] == 1, "R5 new frame first", cap_f[12], 1);
        check_bytes(12, 'h400, 14, "R5 new frame bytes");
    endtask

    task automatic t_exhaust();
        do_reset();
        ring_log = 3'd1;
        put_desc(0, 'h300, 12, 1, 1, 1, 4'hF);
        put_desc(1, 'h400, 12, 1, 1, 1, 4'hF);
        kick();
        chk(n_exh == 1, "R9 exhaust pulse", n_exh, 1);
        chk(ring_idx == 0 && cap_n == 24 && n_tint == 2, "R9 wrap to 0", ring_idx, 0);
    endtask

    task automatic t_gate();
        do_reset();
        put_desc(0, 'h300, 12, 1, 1, 1, 4'hF);
        demand = 1'b1; @(negedge clk); demand = 1'b0;
        cycles(20);
        chk(demand_pend == 1 && n_rd == 0, "R8 held while disabled", demand_pend, 1);
        tx_enable = 1'b1;
        cycles(200);
        chk(demand_pend == 0 && cap_n == 12, "R8 served and cleared", demand_pend, 0);
    endtask

    task automatic t_stall();
        logic [7:0] d0;
        do_reset();
        rdy_mode = 2;
        put_desc(0, 'h302, 12, 1, 1, 1, 4'hF);
        tx_enable = 1'b1;
        demand = 1'b1; @(negedge clk); demand = 1'b0;
        cycles(30);
        d0 = out_data;
        chk(out_valid == 1 && out_first == 1 && d0 == pat('h302), "R10 stall start", d0, pat('h302));
        cycles(10);
        chk(out_valid == 1 && out_first == 1 && out_data == d0, "R10 stall hold", out_data, d0);
        rdy_mode = 0;
        cycles(200);
        chk(cap_n == 12, "R10 resumes", cap_n, 12);
    endtask

    initial begin
        t_reset();
        t_single();
        t_chain();
        t_reject(12, 0, 1, 4'hF, "R3 own clear");
        t_reject(12, 1, 1, 4'hE, "R3 bad nibble");
        t_reject(11, 1, 1, 4'hF, "R4 short count");
        t_reject(1901, 1, 1, 4'hF, "R4 long count");
        t_reject(12, 1, 0, 4'hF, "R5 no start flag");
        t_drop();
        t_exhaust();
        t_gate();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule